// File: doc/BRIEF.md
# Four-Port Programmable Digital I/O Controller

This block sits on a host bus and controls 32 digital channels arranged as four byte-wide ports. Software reaches it through two strobes that share one byte of write data. A command strobe chooses which port later data accesses use. Under a gate bit in the same byte, the command strobe can also set every port to input or output.

A data strobe writes the output latch of the chosen port. The read data always shows the chosen port. For an input port it shows the live pin levels, and for an output port it shows the content of the latch. A per-pin output enable keeps input ports high impedance. All ports come out of reset as inputs.

Top module: `dio_port_ctrl`

## Requirements
- R1: While reset (`rst_n` low) is applied, and after it is released, all ports are inputs. `pin_oe` is all zero, every output latch holds zero and the active port is A.
- R2: Every `cmd_wr` loads `wdata[1:0]` into the active-port register (0 = A, 1 = B, 2 = C, 3 = D), whatever the gate bit holds. Port A is channels 7:0, B is 15:8, C is 23:16 and D is 31:24. Byte bit 0 maps to the lowest channel of a port.
- R3: A `cmd_wr` with `wdata[7]` = 1 sets the direction of ports A, B, C and D from `wdata[3]`, `wdata[4]`, `wdata[5]` and `wdata[6]`. A 1 makes the port an output, and all eight of its `pin_oe` bits go high on the next cycle. A 0 makes the port an input, with its `pin_oe` bits low.
- R4: A `cmd_wr` with `wdata[7]` = 0 leaves every port direction unchanged.
- R5: `wdata[2]` has no effect on a command write. Bits 6:3 have no effect either when `wdata[7]` is 0.
- R6: A `data_wr` to the active port, when that port is an output, stores `wdata` in its latch. From the next cycle on, the latch drives the port's slice of `pin_out`.
- R7: A `data_wr` to the active port, when that port is an input, is ignored. That port's latch keeps its value.
- R8: When the active port is an input, `rdata` is the port's slice of `pin_in`. The path is combinational, so it follows pin changes within the same cycle.
- R9: When the active port is an output, `rdata` is the content of that port's latch.
- R10: If `cmd_wr` and `data_wr` are high in the same cycle, the data write uses the active port and the directions that were in force before that command.
- R11: A latch keeps its value while its port is an input. When the port is made an output again, it drives that value and `rdata` returns it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | Command register write strobe |
| data_wr | input | 1 | Data register write strobe |
| wdata | input | 8 | Write byte shared by both strobes |
| pin_in | input | 32 | Sampled pin levels, channels 31:0 |
| rdata | output | 8 | Read data of the active port |
| pin_out | output | 32 | Output latch values per channel |
| pin_oe | output | 32 | Per-channel output enable, 1 = driven |

## Verification
Directed command bytes separate the two roles of one byte. A byte with the gate clear but all direction bits and bit 2 set must move only the port select. A gated byte must move both the select and the directions. Data writes aimed at input ports and then at output ports show whether the direction register really gates the latch. Read-back after a port is switched to input and back shows whether the latch is kept or cleared. Same-cycle command and data strobes show which select value the data write uses. Mid-cycle pin changes show whether inputs are read live or latched. A long run of random strobes, bytes and pin levels is then checked every cycle against a behavioural model.

// File: rtl/dio_pkg.sv
package dio_pkg;
    localparam int unsigned NPORT    = 4;
    localparam int unsigned PORT_W   = 8;
    localparam int unsigned CMD_W    = 8;
    localparam int unsigned SEL_W    = $clog2(NPORT);
    localparam int unsigned DIR_LSB  = 3;
    localparam int unsigned GATE_BIT = CMD_W - 1;
    localparam int unsigned CHAN_W   = NPORT * PORT_W;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [NPORT-1:0] dir;
    } ctrl_t;
endpackage

// File: rtl/dio_cmd_decode.sv
module dio_cmd_decode
    import dio_pkg::*;
(
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd,
    input  ctrl_t            cur,
    output ctrl_t            nxt
);
    always_comb begin
        nxt = cur;
        if (cmd_wr) begin
            // select always follows the command byte
            nxt.sel = cmd[SEL_W-1:0];
            if (cmd[GATE_BIT]) begin
                nxt.dir = cmd[DIR_LSB +: NPORT];
            end
        end
    end
endmodule

// File: rtl/dio_port_latch.sv
module dio_port_latch #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (wr_en) begin
            q_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign q = q_q;
endmodule

// File: rtl/dio_read_mux.sv
module dio_read_mux
    import dio_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [NPORT-1:0]  dir,
    input  logic [CHAN_W-1:0] lat,
    input  logic [CHAN_W-1:0] pins,
    output logic [PORT_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        for (int p = 0; p < int'(NPORT); p++) begin
            if (sel == SEL_W'(p)) begin
                rdata = dir[p] ? lat[p*PORT_W +: PORT_W] : pins[p*PORT_W +: PORT_W];
            end
        end
    end
endmodule

// File: rtl/dio_port_ctrl.sv
module dio_port_ctrl
    import dio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              data_wr,
    input  logic [CMD_W-1:0]  wdata,
    input  logic [CHAN_W-1:0] pin_in,
    output logic [PORT_W-1:0] rdata,
    output logic [CHAN_W-1:0] pin_out,
    output logic [CHAN_W-1:0] pin_oe
);
    ctrl_t ctrl_d, ctrl_q;
    logic [CHAN_W-1:0] lat_flat;

    dio_cmd_decode u_dec (
        .cmd_wr (cmd_wr),
        .cmd    (wdata),
        .cur    (ctrl_q),
        .nxt    (ctrl_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    for (genvar p = 0; p < int'(NPORT); p++) begin : g_port
        logic wr_hit;
        // write only lands on the current port when it is an output
        assign wr_hit = data_wr && (ctrl_q.sel == SEL_W'(p)) && ctrl_q.dir[p];

        dio_port_latch #(.W(PORT_W)) u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_hit),
            .wdata (wdata[PORT_W-1:0]),
            .q     (lat_flat[p*PORT_W +: PORT_W])
        );

        assign pin_oe[p*PORT_W +: PORT_W] = {PORT_W{ctrl_q.dir[p]}};

        // R3
        dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_wr && wdata[GATE_BIT]) |=>
                (pin_oe[p*PORT_W +: PORT_W] == {PORT_W{$past(wdata[DIR_LSB + p])}}));

        // R6
        latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (data_wr && ctrl_q.sel == SEL_W'(p) && pin_oe[p*PORT_W]) |=>
                (pin_out[p*PORT_W +: PORT_W] == $past(wdata[PORT_W-1:0])));
    end

    assign pin_out = lat_flat;

    dio_read_mux u_mux (
        .sel   (ctrl_q.sel),
        .dir   (ctrl_q.dir),
        .lat   (lat_flat),
        .pins  (pin_in),
        .rdata (rdata)
    );

    // R1
    reset_hiz_chk: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '0));

    // R4
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !wdata[GATE_BIT]) |=> $stable(pin_oe));

    // R7
    input_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !ctrl_q.dir[ctrl_q.sel]) |=> $stable(pin_out));
endmodule

// File: tb/dio_port_ctrl_test.sv
module dio_port_ctrl_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic        data_wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [31:0] pin_in = 32'h5A3C_96E1;
    logic [7:0]  rdata;
    logic [31:0] pin_out, pin_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    bit         m_dir[4];
    int         m_sel;
    logic [7:0] m_lat[4];

    dio_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr),
        .wdata(wdata), .pin_in(pin_in), .rdata(rdata),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd();
        return m_dir[m_sel] ? m_lat[m_sel] : pin_in[m_sel*8 +: 8];
    endfunction

    task automatic compare();
        for (int p = 0; p < 4; p++) begin
            chk("R3 pin_oe", {24'h0, pin_oe[p*8 +: 8]}, m_dir[p] ? 32'hff : 32'h0);
            chk("R6 pin_out", {24'h0, pin_out[p*8 +: 8]}, {24'h0, m_lat[p]});
        end
        chk(m_dir[m_sel] ? "R9 readback" : "R8 live input", {24'h0, rdata}, {24'h0, exp_rd()});
    endtask

    // one cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic step(bit c, bit d, logic [7:0] w);
        cmd_wr = c; data_wr = d; wdata = w;
        @(posedge clk);
        if (d && m_dir[m_sel]) m_lat[m_sel] = w;
        if (c) begin
            m_sel = int'(w[1:0]);
            if (w[7]) for (int p = 0; p < 4; p++) m_dir[p] = w[3+p];
        end
        @(negedge clk);
        cmd_wr = 1'b0; data_wr = 1'b0;
        compare();
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1 got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_sel = 0;
        for (int p = 0; p < 4; p++) begin m_dir[p] = 1'b0; m_lat[p] = 8'h00; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 oe", pin_oe, 32'h0);
        chk("R1 out", pin_out, 32'h0);
        chk("R1 rdata", {24'h0, rdata}, {24'h0, pin_in[7:0]});
        rst_n = 1'b1;
        @(negedge clk);
        compare();

        // R2 select port C, no gate
        step(1, 0, 8'h02);
        chk("R2 sel C", {24'h0, rdata}, {24'h0, pin_in[23:16]});
        // R4 R5 gate clear, dir bits and bit2 set -> only select B moves
        step(1, 0, 8'h7D);
        chk("R4 dirs kept", pin_oe, 32'h0);
        chk("R5 sel B", {24'h0, rdata}, {24'h0, pin_in[15:8]});
        // R3 port A output
        step(1, 0, 8'h88);
        chk("R3 A out", pin_oe, 32'h0000_00ff);
        // R6 R9 write A
        step(0, 1, 8'hA5);
        chk("R6 A latch", {24'h0, pin_out[7:0]}, 32'hA5);
        pin_in = 32'hFFFF_FF00; #1;
        chk("R9 A readback", {24'h0, rdata}, 32'hA5);
        @(negedge clk);
        // R7 write to input port B ignored
        step(1, 0, 8'h89);
        step(0, 1, 8'h3C);
        step(1, 0, 8'h99);
        chk("R7 B latch", {24'h0, rdata}, 32'h00);
        chk("R7 B pins", {24'h0, pin_out[15:8]}, 32'h00);
        // R10 data uses old select (B out), command moves to A, all out
        step(1, 1, 8'hF8);
        chk("R10 B got byte", {24'h0, pin_out[15:8]}, 32'hF8);
        chk("R10 all out", pin_oe, 32'hFFFF_FFFF);
        chk("R10 sel A", {24'h0, rdata}, 32'hA5);
        step(1, 0, 8'h82);
        step(1, 1, 8'hA2);
        chk("R10 C input write dropped", {24'h0, pin_out[23:16]}, 32'h00);
        // R11 latch kept through input phase
        step(1, 0, 8'h80);
        chk("R11 oe off", pin_oe, 32'h0);
        // R8 instantaneous input
        pin_in = 32'h0000_0033; #1;
        chk("R8 live", {24'h0, rdata}, 32'h33);
        pin_in = 32'h0000_00C4; #1;
        chk("R8 live change", {24'h0, rdata}, 32'hC4);
        @(negedge clk);
        step(1, 0, 8'h88);
        chk("R11 A restored", {24'h0, rdata}, 32'hA5);

        // random traffic against the model
        for (int i = 0; i < 400; i++) begin
            pin_in = $urandom;
            step(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), 8'($urandom));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule